// File: doc/BRIEF.md
# Four-Line Host Byte Receiver

This block takes configuration bytes from a host microcontroller over four slow, level-driven lines. The lines are asynchronous to the system clock. The host changes one line per update, at most about once a millisecond. The receiver synchronizes the lines and reads a framing and strobe convention from their levels. It builds each byte out of 2-bit groups and presents the finished byte with a one-cycle valid pulse.

The line roles are fixed. Line 1 (`hostLines[0]`) frames a transfer: while it is high the receiver stays idle and empty, and a transfer starts when it falls. Line 2 (`hostLines[1]`) is a toggle strobe: each change of its level, in either direction, takes in one group. Lines 3 and 4 (`hostLines[2]`, `hostLines[3]`) carry the group bits. Because the host moves one line per update, it puts the data bits on the lines first and toggles the strobe on a later update.

The receiver also copes with the host's power-up routine, which flips all four lines together. It does not mistake that routine for data.

Top module: `hostLinkRx`

## Requirements
- R1: Each line passes through a two-flop synchronizer. When the strobe change that completes a byte is applied between clock edges, `rxValid` is low after the second rising edge that follows and high after the third.
- R2: While the synchronized frame line is high, strobe changes capture nothing and produce no byte.
- R3: Each strobe change, rising or falling, while a transfer is open captures one group. The group is {line 3, line 4}, with line 3 as the group's MSB. Groups arrive MSB group first, so the byte is g0<<6 | g1<<4 | g2<<2 | g3.
- R4: On the fourth capture the byte is loaded into `rxByte` and `rxValid` is high for exactly one cycle. `rxByte` then holds its value until the next completed byte.
- R5: After reset no transfer is accepted until the frame line has been seen high at least once.
- R6: A strobe change in the same cycle as a frame-line change is ignored. When the frame line rises, any partly assembled byte is thrown away.
- R7: A burst in which all four lines flip together, repeated any number of times, produces no byte and leaves `rxByte` unchanged.
- R8: If no strobe change arrives for `TIMEOUT_CYCLES` clocks while a byte is partly assembled, the partial byte is thrown away. Gaps shorter than the timeout keep it.
- R9: Changes on the data lines without a strobe change capture nothing.
- R10: While reset is applied and right after it, `rxValid` is 0 and `rxByte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hostLines | input | 4 | Raw host lines: [0] frame, [1] strobe, [2] group MSB, [3] group LSB |
| rxValid | output | 1 | One-cycle pulse when a byte completes |
| rxByte | output | BYTE_BITS (8) | Last completed byte |

## Verification
Two events can land in the same cycle: the frame line rising and a strobe change. The bench provokes this by flipping both raw lines on the same clock edge after three groups have been sent. Both lines pass through identical synchronizers, so the two changes reach the control logic together. The check is that no byte appears, that `rxByte` keeps its old value, and that the next complete transfer arrives intact. In the same way, a strobe change that coincides with the timeout expiring is judged to extend the partial byte.

// File: rtl/hostLinkRx_pkg.sv
package hostLinkRx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // drop partial byte
    logic capture;  // shift in current group
    logic publish;  // this capture completes the byte
  } linkCtl_t;
endpackage

// File: rtl/linkSync.sv
module linkSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/linkCtrl.sv
module linkCtrl
  import hostLinkRx_pkg::*;
#(
  parameter int GROUPS         = 4,
  parameter int TIMEOUT_CYCLES = 10_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frameLine,
  input  logic     strobeLine,
  output linkCtl_t ctl
);
  localparam int CNT_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);

  logic               primed, armed, prevFrame, prevStrobe;
  logic [CNT_W-1:0]   groupCnt;
  logic [TIMER_W-1:0] idleTimer;
  logic               frameMoved, strobeMoved, openXfer, expired;

  always_comb begin
    frameMoved  = primed && (frameLine != prevFrame);
    strobeMoved = primed && (strobeLine != prevStrobe);
    openXfer    = armed && !frameLine && !frameMoved;
    expired     = (groupCnt != '0) && (idleTimer == TIMER_W'(TIMEOUT_CYCLES - 1));
    ctl.capture = openXfer && strobeMoved;
    ctl.publish = ctl.capture && (groupCnt == CNT_W'(GROUPS - 1));
    ctl.clear   = !openXfer || (expired && !ctl.capture);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed     <= 1'b0;
      armed      <= 1'b0;
      prevFrame  <= 1'b0;
      prevStrobe <= 1'b0;
      groupCnt   <= '0;
      idleTimer  <= '0;
    end else begin
      primed     <= 1'b1;
      armed      <= armed | frameLine;
      prevFrame  <= frameLine;
      prevStrobe <= strobeLine;
      if (ctl.clear)        groupCnt <= '0;
      else if (ctl.publish) groupCnt <= '0;
      else if (ctl.capture) groupCnt <= groupCnt + 1'b1;
      if (ctl.clear || ctl.capture || groupCnt == '0) idleTimer <= '0;
      else                                            idleTimer <= idleTimer + 1'b1;
    end
  end
endmodule

// File: rtl/linkDatapath.sv
module linkDatapath
  import hostLinkRx_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int GROUP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  linkCtl_t             ctl,
  input  logic [GROUP_BITS-1:0] group,
  output logic                 rxValid,
  output logic [BYTE_BITS-1:0] rxByte
);
  localparam int PART_W = BYTE_BITS - GROUP_BITS;

  logic [PART_W-1:0] partial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partial <= '0;
      rxValid <= 1'b0;
      rxByte  <= '0;
    end else begin
      rxValid <= ctl.publish;
      if (ctl.publish) rxByte <= {partial, group};
      if (ctl.clear || ctl.publish) partial <= '0;
      else if (ctl.capture)         partial <= {partial[PART_W-GROUP_BITS-1:0], group};
    end
  end
endmodule

// File: rtl/hostLinkRx.sv
module hostLinkRx
  import hostLinkRx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BYTE_BITS      = 8,
  parameter int TIMEOUT_CYCLES = 10_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           hostLines,
  output logic                 rxValid,
  output logic [BYTE_BITS-1:0] rxByte
);
  localparam int GROUP_BITS = 2;
  localparam int GROUPS     = BYTE_BITS / GROUP_BITS;

  logic [3:0] lineSync;
  linkCtl_t   ctl;

  linkSync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(hostLines), .dout(lineSync)
  );

  linkCtrl #(.GROUPS(GROUPS), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .frameLine(lineSync[0]), .strobeLine(lineSync[1]), .ctl(ctl)
  );

  linkDatapath #(.BYTE_BITS(BYTE_BITS), .GROUP_BITS(GROUP_BITS)) data_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .group({lineSync[2], lineSync[3]}),
    .rxValid(rxValid), .rxByte(rxByte)
  );
endmodule

// File: rtl/hostLinkRx_checker.sv
module hostLinkRx_checker
  import hostLinkRx_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           lineSync,
  input linkCtl_t             ctl,
  input logic                 rxValid,
  input logic [BYTE_BITS-1:0] rxByte
);
  assert_frame_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lineSync[0] |-> !ctl.capture);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  assert_publish_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.publish |=> rxValid);

  assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rxValid |-> $stable(rxByte));

  assert_frame_edge_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lineSync[0] != $past(lineSync[0])) |-> !ctl.capture);
endmodule

bind hostLinkRx hostLinkRx_checker #(.BYTE_BITS(BYTE_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .lineSync(lineSync), .ctl(ctl),
  .rxValid(rxValid), .rxByte(rxByte)
);

// File: tb/hostLinkRx_tb_top.sv
`timescale 1ns/1ps
module hostLinkRx_tb_top;
  localparam int GAP = 8;
  localparam int TMO = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lines = 4'b0000;
  logic       rxValid;
  logic [7:0] rxByte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       prevValid = 1'b0;

  always #2.5 clk = ~clk;

  hostLinkRx #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .hostLines(lines), .rxValid(rxValid), .rxByte(rxByte)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setLine(input int idx, input logic v);
    @(negedge clk);
    lines[idx] = v;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic sendGroup(input logic [1:0] g);
    setLine(2, g[1]);
    setLine(3, g[0]);
    setLine(1, ~lines[1]);
  endtask

  task automatic openFrame();
    setLine(0, 1'b1);
    setLine(0, 1'b0);
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
    openFrame();
    for (int i = 3; i >= 0; i--) sendGroup(b[2*i +: 2]);
    setLine(0, 1'b1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rxValid && prevValid) check(1'b0, "R4 valid wider than one cycle", rxByte, 8'h00);
      if (rxValid) begin
        if (expQ.size() == 0) check(1'b0, "R4 unexpected byte", rxByte, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(rxByte == e, t, rxByte, e);
        end
      end
      prevValid = rxValid;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    check(rxValid == 1'b0, "R10 valid in reset", {7'd0, rxValid}, 8'h00);
    check(rxByte == 8'h00, "R10 byte in reset", rxByte, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(rxValid == 1'b0, "R10 valid after reset", {7'd0, rxValid}, 8'h00);
    check(rxByte == 8'h00, "R10 byte after reset", rxByte, 8'h00);

    // R5: frame never high yet, strobes must be ignored
    sendGroup(2'b11); sendGroup(2'b01); sendGroup(2'b10); sendGroup(2'b11);
    repeat (20) @(negedge clk);
    check(rxByte == 8'h00, "R5 unarmed capture", rxByte, 8'h00);

    // R1 latency with byte A5 (groups 2,2,1,1), R3 ordering
    expQ.push_back(8'hA5); tagQ.push_back("R3 byte A5");
    openFrame();
    sendGroup(2'b10); sendGroup(2'b10); sendGroup(2'b01);
    setLine(2, 1'b0); setLine(3, 1'b1);
    @(negedge clk);
    lines[1] = ~lines[1];
    @(posedge clk); @(posedge clk); #1;
    check(rxValid == 1'b0, "R1 valid too early", {7'd0, rxValid}, 8'h00);
    @(posedge clk); #1;
    check(rxValid == 1'b1, "R1 valid at third edge", {7'd0, rxValid}, 8'h01);
    repeat (GAP) @(negedge clk);
    setLine(0, 1'b1);

    sendByte(8'h00, "R3 byte 00");
    sendByte(8'hFF, "R3 byte FF");
    repeat (50) @(negedge clk);
    check(rxByte == 8'hFF, "R4 byte holds", rxByte, 8'hFF);
    sendByte(8'h3C, "R3 byte 3C");

    // R9: data wiggles between groups
    expQ.push_back(8'h5A); tagQ.push_back("R9 wiggled byte 5A");
    openFrame();
    for (int i = 3; i >= 0; i--) begin
      setLine(2, 1'b1); setLine(3, 1'b0); setLine(2, 1'b0); setLine(3, 1'b1);
      sendGroup(8'h5A >> (2*i));
    end
    setLine(0, 1'b1);

    // R2: frame high, strobe toggles ignored
    held = rxByte;
    for (int i = 0; i < 4; i++) sendGroup(2'b01);
    repeat (20) @(negedge clk);
    check(rxByte == held, "R2 frame high capture", rxByte, held);

    // R6 collision: frame rises together with a strobe change
    openFrame();
    sendGroup(2'b11); sendGroup(2'b00); sendGroup(2'b11);
    @(negedge clk);
    lines[0] = 1'b1;
    lines[1] = ~lines[1];
    repeat (20) @(negedge clk);
    check(rxByte == held, "R6 collision made byte", rxByte, held);
    sendByte(8'hC3, "R6 byte after collision");
    // R6 partial discarded on frame rise
    openFrame();
    sendGroup(2'b10); sendGroup(2'b01);
    sendByte(8'h96, "R6 byte after discard");

    // R7 init bursts: even then odd count of all-line flips
    held = 8'h96;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); lines = ~lines; repeat (GAP) @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); lines = ~lines; repeat (GAP) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(rxByte == held, "R7 burst changed byte", rxByte, held);
    sendByte(8'h7E, "R7 byte after burst");

    // R8 timeout discards partial byte
    openFrame();
    sendGroup(2'b11); sendGroup(2'b00);
    repeat (TMO + 100) @(negedge clk);
    expQ.push_back(8'h1B); tagQ.push_back("R8 byte after timeout");
    sendGroup(2'b00); sendGroup(2'b01); sendGroup(2'b10); sendGroup(2'b11);
    setLine(0, 1'b1);

    // R8 gaps below the timeout keep the byte
    expQ.push_back(8'hE4); tagQ.push_back("R8 slow byte kept");
    openFrame();
    for (int i = 3; i >= 0; i--) begin
      sendGroup(8'hE4 >> (2*i));
      if (i != 0) repeat (TMO - 50) @(negedge clk);
    end
    setLine(0, 1'b1);

    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R4 missing bytes", 8'(expQ.size()), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule